// File: doc/BRIEF.md
# Oversampling Baud Clock Generator

This block turns the processor clock into the timing references of an asynchronous serial port. A 16-bit divisor sets how many processor cycles each half period of a toggling 16x serial clock lasts. The count uses the divisor plus one, so a divisor of zero still gives a two-cycle 16x period, and the baud rate is the clock frequency divided by 32 times (divisor + 1). The block divides the 16x clock by sixteen to make a one-cycle baud strobe for the transmitter and the receiver.

The divisor is loaded through a single-cycle write strobe with a data word. A write restarts the current half period with the new value, so a rate change after a clock-frequency switch takes effect at once and no long stale period runs out first. A generator enable holds the 16x clock, its strobe and the baud strobe low, and keeps the phase counter cleared, while software has not yet programmed a divisor. The reset value of the divisor is not meant to be relied on.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `clk16_o`, `tick16_o` and `baud_stb_o` are all 0.
- R2: With `gen_en` high and no writes, `clk16_o` stays at each level for exactly divisor + 1 processor cycles, giving a period of 2 x (divisor + 1) cycles.
- R3: A divisor of 0 gives a 16x period of 2 cycles and a baud strobe every 32 cycles.
- R4: `tick16_o` is high for exactly one cycle, the first cycle in which `clk16_o` is high after having been low; it is never high at any other time.
- R5: `baud_stb_o` is high for one cycle on every 16th `tick16_o` after enabling, in the same cycle as that tick, and never without a tick.
- R6: A write (`div_wr` = 1) stores `div_wdata`, leaves the level of `clk16_o` unchanged and makes the next level change happen new-divisor + 1 cycles after the write edge.
- R7: While `gen_en` is low, all three outputs are 0 from the cycle after it falls. When `gen_en` rises, the first rising edge of `clk16_o` comes divisor + 1 cycles later, and the first baud strobe comes on the 16th tick.
- R8: A divisor written while `gen_en` is low is kept and sets the timing once the generator is enabled.
- R9: The full 16-bit divisor 0xFFFF gives half periods of 65536 cycles, a 16x period of 131072 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generator enable; low holds outputs low |
| div_wr | input | 1 | One-cycle divisor write strobe |
| div_wdata | input | 16 | Divisor value to load |
| clk16_o | output | 1 | 16x serial clock, toggling every divisor + 1 cycles |
| tick16_o | output | 1 | One-cycle strobe in the first high cycle of `clk16_o` |
| baud_stb_o | output | 1 | One-cycle strobe once per 16 ticks |

## Verification
All three outputs come from registers. A toggle is due at the edge where the half-period count has reached zero, which is divisor + 1 edges after enabling, after a write or after the previous toggle, and the tick and baud strobe appear in the same cycle as the rising level. The bench drives inputs and samples outputs on the falling edge. A behavioural model, advanced on the rising edge from a cycles-since-toggle count, is compared with all three outputs every cycle. Directed checks count the falling edges from the stimulus to each level change and compare the count with divisor + 1.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // True when the phase counter sits on its final oversampling slot.
  function automatic logic phase_is_last(input int unsigned phase, input int unsigned ovs);
    return phase == ovs - 1;
  endfunction

  // Next phase value, wrapping to zero after the last slot.
  function automatic int unsigned phase_next(input int unsigned phase, input int unsigned ovs);
    return (phase == ovs - 1) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/bg_half_ctr.sv
module bg_half_ctr #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr,
  input  logic [DIV_W-1:0] wdata,
  output logic             lvl_o,
  output logic             rise_evt_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             lvl_q;
  logic             cnt_zero;
  logic             toggle_evt;

  assign cnt_zero   = (cnt_q == '0);
  assign toggle_evt = en && !wr && cnt_zero;
  assign rise_evt_o = toggle_evt && !lvl_q;
  assign lvl_o      = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  div_q <= '0;
    else if (wr) div_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (wr)               cnt_q <= wdata;
    else if (!en || cnt_zero)  cnt_q <= div_q;
    else                       cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)   lvl_q <= 1'b0;
    else if (toggle_evt) lvl_q <= ~lvl_q;
  end

  // R2: the level only moves after the count has run down to zero
  p_toggle_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && lvl_q != $past(lvl_q)) |-> $past(cnt_q) == '0);

  // R6: a write reloads the count and leaves the level alone
  p_write_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && en) |=> (cnt_q == $past(wdata)) && (lvl_q == $past(lvl_q)));

  // R2: the remaining count never exceeds the stored divisor
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

endmodule

// File: rtl/bg_ovs_div.sv
module bg_ovs_div #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise_evt,
  output logic tick_o,
  output logic stb_o
);
  import baudgen_pkg::*;

  localparam int SUB_W = $clog2(OVS);

  logic [SUB_W-1:0] phase_q;
  logic             wrap_evt;

  assign wrap_evt = rise_evt && phase_is_last(int'(phase_q), OVS);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) phase_q <= '0;
    else if (rise_evt) phase_q <= SUB_W'(phase_next(int'(phase_q), OVS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      tick_o <= 1'b0;
      stb_o  <= 1'b0;
    end else begin
      tick_o <= rise_evt;
      stb_o  <= wrap_evt;
    end
  end

  // R5: a baud strobe follows only a wrap of the phase counter
  p_stb_after_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> $past(phase_q) == SUB_W'(OVS - 1) || $past(!en));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             clk16_o,
  output logic             tick16_o,
  output logic             baud_stb_o
);

  logic rise_evt;

  bg_half_ctr #(.DIV_W(DIV_W)) u_half (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (gen_en),
    .wr         (div_wr),
    .wdata      (div_wdata),
    .lvl_o      (clk16_o),
    .rise_evt_o (rise_evt)
  );

  bg_ovs_div #(.OVS(OVS)) u_ovs (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (gen_en),
    .rise_evt (rise_evt),
    .tick_o   (tick16_o),
    .stb_o    (baud_stb_o)
  );

  // R4: the tick marks the first high cycle of the 16x clock
  p_tick_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick16_o |-> clk16_o && !$past(clk16_o));

  // R4: every rising level is accompanied by a tick
  p_rise_has_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk16_o && !$past(clk16_o)) |-> tick16_o);

  // R5: no baud strobe without a tick
  p_stb_with_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    baud_stb_o |-> tick16_o);

  // R7: disabled generator is silent
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !clk16_o && !tick16_o && !baud_stb_o);

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0;
  logic        div_wr = 1'b0;
  logic [15:0] div_wdata = '0;
  logic        clk16_o, tick16_o, baud_stb_o;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .div_wr(div_wr),
    .div_wdata(div_wdata), .clk16_o(clk16_o), .tick16_o(tick16_o),
    .baud_stb_o(baud_stb_o)
  );

  // Reference: cycles since last level change, stored divisor, tick tally
  int  m_div = 0, m_age = 0, m_ticks = 0;
  bit  m_lvl = 0, m_tk = 0, m_sb = 0;

  always @(posedge clk) begin
    cyc++;
    m_tk = 0; m_sb = 0;
    if (!rst_n) begin
      m_div = 0; m_age = 0; m_ticks = 0; m_lvl = 0;
    end else if (!gen_en) begin
      if (div_wr) m_div = div_wdata;
      m_age = 0; m_lvl = 0; m_ticks = 0;
    end else if (div_wr) begin
      m_div = div_wdata; m_age = 0;
    end else if (m_age == m_div) begin
      m_age = 0;
      if (!m_lvl) begin
        m_ticks++;
        m_tk = 1;
        if (m_ticks % 16 == 0) m_sb = 1;
      end
      m_lvl = !m_lvl;
    end else begin
      m_age++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(clk16_o == m_lvl,   "R2 clk16 vs model", clk16_o, m_lvl);
      check(tick16_o == m_tk,   "R4 tick16 vs model", tick16_o, m_tk);
      check(baud_stb_o == m_sb, "R5 baud strobe vs model", baud_stb_o, m_sb);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 195000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      finish_run();
    end
  end

  // Count falling edges until clk16 reaches the wanted level
  task automatic wait_level(input bit lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clk16_o != lvl && n < 140000);
  endtask

  // Disable, load divisor, enable, measure both half periods
  task automatic measure(input int div, input string req);
    int n;
    @(negedge clk);
    gen_en = 0; div_wr = 1; div_wdata = 16'(div);
    @(negedge clk);
    div_wr = 0; gen_en = 1;
    wait_level(1'b1, n);
    check(n == div + 1, req, n, div + 1);
    check(tick16_o == 1'b1, "R4 tick at first high cycle", tick16_o, 1);
    wait_level(1'b0, n);
    check(n == div + 1, req, n, div + 1);
  endtask

  initial begin
    int n;
    int t;
    repeat (3) @(negedge clk);
    check({clk16_o, tick16_o, baud_stb_o} == 3'b000, "R1 outputs during reset", {clk16_o, tick16_o, baud_stb_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check({clk16_o, tick16_o, baud_stb_o} == 3'b000, "R1 outputs after reset", {clk16_o, tick16_o, baud_stb_o}, 0);

    measure(0,   "R3 half period divisor 0");
    // R3: baud strobe spacing at divisor 0
    n = 0;
    while (!baud_stb_o && n < 100) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!baud_stb_o && n < 100);
    check(n == 32, "R3 baud strobe spacing", n, 32);

    measure(1,   "R2 half period divisor 1");
    // R5/R7: first baud strobe comes with the 16th tick after enable
    t = 1;
    n = 0;
    while (!baud_stb_o && n < 200) begin
      @(negedge clk); n++;
      if (tick16_o) t++;
    end
    check(t == 16, "R5 ticks up to first baud strobe", t, 16);

    measure(129, "R2 half period divisor 129");

    // R6: write during a running phase restarts it
    repeat (50) @(negedge clk);
    begin
      bit lv;
      lv = clk16_o;
      div_wr = 1; div_wdata = 16'd3;
      @(negedge clk);
      div_wr = 0;
      check(clk16_o == lv, "R6 level kept across write", clk16_o, lv);
      n = 0;
      do begin @(negedge clk); n++; end while (clk16_o == lv && n < 1000);
      check(n == 4, "R6 restart after write", n, 4);
    end

    // R7: disable mid-run, outputs held low
    gen_en = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check({clk16_o, tick16_o, baud_stb_o} == 3'b000, "R7 disabled outputs low", {clk16_o, tick16_o, baud_stb_o}, 0);
    end

    // R8: divisor written while disabled is retained
    div_wr = 1; div_wdata = 16'd5;
    @(negedge clk);
    div_wr = 0;
    repeat (10) @(negedge clk);
    gen_en = 1;
    wait_level(1'b1, n);
    check(n == 6, "R8 divisor kept while disabled", n, 6);

    measure(16'hFFFF, "R9 half period divisor 0xFFFF");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule